// File: doc/BRIEF.md
# GPIO Register and Interrupt File with APB Access

This block is the software-facing half of an eight-pin general purpose I/O unit. It sits on an APB bus as a zero-wait-state slave. It holds the pin output values and the per-pin direction bits, and it drives both onto plain outputs for the pin core. It also returns the already-synchronized pin levels that the pin core supplies.

The block collects 32 interrupt conditions from the pin core. These are one pulse per pin and per condition: level high, level low, rising edge and falling edge. It latches each condition into a sticky raw status bit. Software enables sources through a mask, reads a raw view and a masked view, and acknowledges sources by writing ones to a clear register. A single registered interrupt request goes high whenever any enabled source is pending.

Top module: `gpio_apb_regs`

## Requirements
- R1: After reset, dout_o, dir_o and irq_o are 0, and every register reads back as 0.
- R2: A write to offset 0x004 stores pwdata[7:0] as the pin output values. dout_o shows them from the cycle after the access phase. A read of 0x004 returns them in bits 7:0, with bits 31:8 as 0.
- R3: A write to offset 0x008 stores pwdata[7:0] as the direction bits, where 1 means output and 0 means input. dir_o shows them from the cycle after the access phase, and a read of 0x008 returns them zero-extended.
- R4: A read of offset 0x000 returns pin_sync_i in bits 7:0 and 0 in bits 31:8. A write to 0x000 changes nothing.
- R5: pready is always 1 and pslverr is always 0. Reads of unmapped offsets return 0, and writes to unmapped offsets change no register.
- R6: Raw status is read at 0xF08. Bit n is set by a pulse on cond_i[n] and then held until cleared, whatever the mask holds. Bits 7:0 are pin-high for pins 0..7, bits 15:8 are pin-low, bits 23:16 are rising edge and bits 31:24 are falling edge. Writes to 0xF08 are ignored.
- R7: The mask is read and written at 0xF00. Masked status at 0xF04 reads as raw status AND mask. Writes to 0xF04 are ignored.
- R8: Writing 1 to bit n of offset 0xF0C clears raw status bit n, and with it masked bit n. Writing 0 leaves the bit unchanged. Reads of 0xF0C return 0.
- R9: When a condition pulse and a clear of the same bit fall in the same cycle, the bit ends up set.
- R10: irq_o is the registered OR of the masked status bits. It changes one cycle after the raw status or mask change that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB slave select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 12 | APB byte offset |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the access phase |
| pready | output | 1 | Always 1 (no wait states) |
| pslverr | output | 1 | Always 0 |
| pin_sync_i | input | 8 | Synchronized pin levels from the pin core |
| cond_i | input | 32 | Per-pin condition pulses (high, low, rise, fall groups) |
| dout_o | output | 8 | Pin output values |
| dir_o | output | 8 | Pin direction, 1 = output |
| irq_o | output | 1 | Interrupt request |

## Verification
Read data is combinational during the access phase. The bench therefore samples prdata a moment after penable rises, still ahead of the edge that completes the transfer. Register writes and condition pulses take effect at the edge that samples them, so dout_o, dir_o and the status registers are checked at the falling edge that follows. irq_o has one more register stage, so it is checked twice: once at that same falling edge, where it must still hold its old value, and again one full cycle later, where it must show the new value. The same-cycle case holds the condition pulse high in exactly the access-phase cycle of the clear write.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;

  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFF_DIN  = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_DOUT = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_DIR  = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_MASK = 12'hF00;
  localparam logic [ADDR_W-1:0] OFF_MIS  = 12'hF04;
  localparam logic [ADDR_W-1:0] OFF_RIS  = 12'hF08;
  localparam logic [ADDR_W-1:0] OFF_CLR  = 12'hF0C;

  // one write strobe per writable register
  typedef struct packed {
    logic dout;
    logic dir;
    logic mask;
    logic clr;
  } wr_sel_t;

endpackage

// File: rtl/gpio_apb_decode.sv
module gpio_apb_decode
  import gpio_regs_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned NP = 8,
  parameter int unsigned NS = 4 * NP
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [NP-1:0]     din,
  input  logic [NP-1:0]     dout,
  input  logic [NP-1:0]     dir,
  input  logic [NS-1:0]     mask,
  input  logic [NS-1:0]     ris,
  input  logic [NS-1:0]     mis,
  output wr_sel_t           wsel,
  output logic [DW-1:0]     prdata
);

  logic acc_wr;
  logic acc_rd;

  always_comb begin
    acc_wr = psel & penable & pwrite;
    acc_rd = psel & penable & ~pwrite;
  end

  // write strobes; offsets without a writable register fall through
  always_comb begin
    wsel = '0;
    if (acc_wr) begin
      case (paddr)
        OFF_DOUT: wsel.dout = 1'b1;
        OFF_DIR:  wsel.dir  = 1'b1;
        OFF_MASK: wsel.mask = 1'b1;
        OFF_CLR:  wsel.clr  = 1'b1;
        default:  ;
      endcase
    end
  end

  // read mux, zero outside an access-phase read
  always_comb begin
    prdata = '0;
    if (acc_rd) begin
      case (paddr)
        OFF_DIN:  prdata[NP-1:0] = din;
        OFF_DOUT: prdata[NP-1:0] = dout;
        OFF_DIR:  prdata[NP-1:0] = dir;
        OFF_MASK: prdata[NS-1:0] = mask;
        OFF_MIS:  prdata[NS-1:0] = mis;
        OFF_RIS:  prdata[NS-1:0] = ris;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs #(
  parameter int unsigned NP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_dout,
  input  logic          wr_dir,
  input  logic [NP-1:0] wdata,
  output logic [NP-1:0] dout_q,
  output logic [NP-1:0] dir_q
);

  logic [NP-1:0] dout_n;
  logic [NP-1:0] dir_n;

  always_comb begin
    dout_n = dout_q;
    dir_n  = dir_q;
    if (wr_dout) dout_n = wdata;
    if (wr_dir)  dir_n  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
    end else begin
      dout_q <= dout_n;
      dir_q  <= dir_n;
    end
  end

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int unsigned NS = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] cond_i,
  input  logic          wr_mask,
  input  logic          wr_clr,
  input  logic [NS-1:0] wdata,
  output logic [NS-1:0] mask_q,
  output logic [NS-1:0] ris_q,
  output logic [NS-1:0] mis,
  output logic          irq_q
);

  logic [NS-1:0] mask_n;
  logic [NS-1:0] clr_vec;
  logic          irq_n;

  always_comb begin
    clr_vec = wr_clr ? wdata : '0;
    mask_n  = wr_mask ? wdata : mask_q;
    mis     = ris_q & mask_q;
    irq_n   = |mis;
  end

  // one sticky flag per source; a pulse outranks a clear in the same cycle
  for (genvar i = 0; i < NS; i++) begin : g_src
    logic flag_q;
    logic flag_n;

    always_comb flag_n = cond_i[i] | (flag_q & ~clr_vec[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_n;
    end

    assign ris_q[i] = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_n;
      irq_q  <= irq_n;
    end
  end

endmodule

// File: rtl/gpio_apb_regs.sv
module gpio_apb_regs
  import gpio_regs_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                  pclk,
  input  logic                  presetn,
  input  logic                  psel,
  input  logic                  penable,
  input  logic                  pwrite,
  input  logic [ADDR_W-1:0]     paddr,
  input  logic [DATA_W-1:0]     pwdata,
  output logic [DATA_W-1:0]     prdata,
  output logic                  pready,
  output logic                  pslverr,
  input  logic [NUM_PINS-1:0]   pin_sync_i,
  input  logic [4*NUM_PINS-1:0] cond_i,
  output logic [NUM_PINS-1:0]   dout_o,
  output logic [NUM_PINS-1:0]   dir_o,
  output logic                  irq_o
);

  localparam int unsigned NUM_SRC = 4 * NUM_PINS;

  wr_sel_t              wsel;
  logic [NUM_SRC-1:0]   mask_q;
  logic [NUM_SRC-1:0]   ris_q;
  logic [NUM_SRC-1:0]   mis;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  gpio_apb_decode #(
    .DW (DATA_W),
    .NP (NUM_PINS),
    .NS (NUM_SRC)
  ) u_dec (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .din     (pin_sync_i),
    .dout    (dout_o),
    .dir     (dir_o),
    .mask    (mask_q),
    .ris     (ris_q),
    .mis     (mis),
    .wsel    (wsel),
    .prdata  (prdata)
  );

  gpio_out_regs #(
    .NP (NUM_PINS)
  ) u_out (
    .clk     (pclk),
    .rst_n   (presetn),
    .wr_dout (wsel.dout),
    .wr_dir  (wsel.dir),
    .wdata   (pwdata[NUM_PINS-1:0]),
    .dout_q  (dout_o),
    .dir_q   (dir_o)
  );

  gpio_irq_unit #(
    .NS (NUM_SRC)
  ) u_irq (
    .clk     (pclk),
    .rst_n   (presetn),
    .cond_i  (cond_i),
    .wr_mask (wsel.mask),
    .wr_clr  (wsel.clr),
    .wdata   (pwdata[NUM_SRC-1:0]),
    .mask_q  (mask_q),
    .ris_q   (ris_q),
    .mis     (mis),
    .irq_q   (irq_o)
  );

endmodule

// File: rtl/gpio_apb_regs_chk.sv
module gpio_apb_regs_chk #(
  parameter int unsigned NP = 8,
  parameter int unsigned DW = 32,
  parameter int unsigned NS = 4 * NP
) (
  input logic          clk,
  input logic          rst_n,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [11:0]   paddr,
  input logic [DW-1:0] pwdata,
  input logic [DW-1:0] prdata,
  input logic          pready,
  input logic          pslverr,
  input logic [NP-1:0] pin_sync_i,
  input logic [NS-1:0] cond_i,
  input logic [NP-1:0] dout_o,
  input logic          irq_o,
  input logic [NS-1:0] ris,
  input logic [NS-1:0] mask
);

  logic          wr_acc;
  logic          rd_acc;
  logic [NS-1:0] clr_seen;

  always_comb begin
    wr_acc   = psel && penable && pwrite;
    rd_acc   = psel && penable && !pwrite;
    clr_seen = (wr_acc && paddr == 12'hF0C) ? pwdata[NS-1:0] : '0;
  end

  AST_BUS_OK: assert property (@(posedge clk) disable iff (!rst_n)
    pready && !pslverr);  // R5

  AST_DOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && paddr == 12'h004) |=> dout_o == $past(pwdata[NP-1:0]));  // R2

  AST_DIN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && paddr == 12'h000) |-> prdata == DW'(pin_sync_i));  // R4

  AST_RIS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($past(cond_i) & ~ris) == '0);  // R9

  AST_RIS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(ris) & ~$past(clr_seen)) & ~ris) == '0);  // R6

  AST_MIS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && paddr == 12'hF04) |-> prdata[NS-1:0] == (ris & mask));  // R7

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> irq_o == $past(|(ris & mask)));  // R10

endmodule

bind gpio_apb_regs gpio_apb_regs_chk #(
  .NP (NUM_PINS),
  .DW (DATA_W),
  .NS (NUM_SRC)
) u_chk (
  .clk        (pclk),
  .rst_n      (presetn),
  .psel       (psel),
  .penable    (penable),
  .pwrite     (pwrite),
  .paddr      (paddr),
  .pwdata     (pwdata),
  .prdata     (prdata),
  .pready     (pready),
  .pslverr    (pslverr),
  .pin_sync_i (pin_sync_i),
  .cond_i     (cond_i),
  .dout_o     (dout_o),
  .irq_o      (irq_o),
  .ris        (ris_q),
  .mask       (mask_q)
);

// File: tb/sim_gpio_apb_regs.sv
`timescale 1ns/1ps
module sim_gpio_apb_regs;

  logic        pclk;
  logic        presetn;
  logic        psel;
  logic        penable;
  logic        pwrite;
  logic [11:0] paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic        pready;
  logic        pslverr;
  logic [7:0]  pin_sync_i;
  logic [31:0] cond_i;
  logic [7:0]  dout_o;
  logic [7:0]  dir_o;
  logic        irq_o;

  int checks;
  int fails;

  gpio_apb_regs u0 (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .pin_sync_i(pin_sync_i),
    .cond_i(cond_i), .dout_o(dout_o), .dir_o(dir_o), .irq_o(irq_o)
  );

  initial pclk = 1'b0;
  always #2 pclk = ~pclk;

  typedef struct packed {
    logic [11:0] waddr;
    logic [31:0] wdata;
    logic [11:0] raddr;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{12'h004, 32'hFFFF_FF5A, 12'h004, 32'h0000_005A},  // R2 zero-extended readback
    '{12'h008, 32'h0000_0F0F, 12'h008, 32'h0000_000F},  // R3
    '{12'hF00, 32'h1234_5678, 12'hF00, 32'h1234_5678},  // R7 mask read/write
    '{12'h100, 32'hFFFF_FFFF, 12'h100, 32'h0000_0000},  // R5 unmapped reads 0
    '{12'h100, 32'hFFFF_FFFF, 12'h004, 32'h0000_005A},  // R5 unmapped write no effect
    '{12'h000, 32'h0000_00FF, 12'h000, 32'h0000_00C3},  // R4 write to input ignored
    '{12'hF04, 32'hFFFF_FFFF, 12'hF00, 32'h1234_5678},  // R7 masked status write ignored
    '{12'hF08, 32'hFFFF_FFFF, 12'hF08, 32'h0000_0000},  // R6 raw status write ignored
    '{12'hF0C, 32'h0000_FFFF, 12'hF0C, 32'h0000_0000},  // R8 clear reads 0
    '{12'h004, 32'h0000_0000, 12'h004, 32'h0000_0000}   // R2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic apb_write(input logic [11:0] a, input logic [31:0] d, input logic [31:0] c);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1; cond_i = c;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; cond_i = '0;
  endtask

  task automatic apb_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    #0.5 d = prdata;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic pulse(input logic [31:0] c);
    @(negedge pclk);
    cond_i = c;
    @(negedge pclk);
    cond_i = '0;
  endtask

  task automatic run_tests();
    logic [31:0] rd;
    // reset state
    check("R1 dout_o", {24'h0, dout_o}, 32'h0);
    check("R1 dir_o", {24'h0, dir_o}, 32'h0);
    check("R1 irq_o", {31'h0, irq_o}, 32'h0);
    check("R5 pready/pslverr", {30'h0, pready, pslverr}, 32'h2);
    foreach (VEC[i]) begin
      apb_read(VEC[i].raddr, rd);
      check("R1 reg reset", rd, 32'h0);
    end

    // vector table
    pin_sync_i = 8'hC3;
    for (int i = 0; i < NV; i++) begin
      apb_write(VEC[i].waddr, VEC[i].wdata, 32'h0);
      apb_read(VEC[i].raddr, rd);
      check($sformatf("table[%0d] R2..R8", i), rd, VEC[i].exp);
    end

    // R2 / R3 at the ports, visible right after the access edge
    apb_write(12'h004, 32'h0000_00A5, 32'h0);
    check("R2 dout_o", {24'h0, dout_o}, 32'hA5);
    apb_write(12'h008, 32'h0000_003C, 32'h0);
    check("R3 dir_o", {24'h0, dir_o}, 32'h3C);

    // R4 different pin pattern
    pin_sync_i = 8'h5E;
    apb_read(12'h000, rd);
    check("R4 din", rd, 32'h0000_005E);

    // R6 sticky with mask cleared, group layout (pin3 high, pin3 fall)
    apb_write(12'hF00, 32'h0, 32'h0);
    apb_write(12'hF0C, 32'hFFFF_FFFF, 32'h0);
    pulse(32'h0800_0008);
    check("R10 irq masked off", {31'h0, irq_o}, 32'h0);
    repeat (3) @(negedge pclk);
    apb_read(12'hF08, rd);
    check("R6 raw sticky", rd, 32'h0800_0008);
    apb_read(12'hF04, rd);
    check("R7 masked zero", rd, 32'h0);
    check("R10 irq stays low", {31'h0, irq_o}, 32'h0);

    // R7 / R10 enable falling-edge group bit of pin 3
    apb_write(12'hF00, 32'h0800_0000, 32'h0);
    check("R10 irq one-cycle lag", {31'h0, irq_o}, 32'h0);
    @(negedge pclk);
    check("R10 irq raised", {31'h0, irq_o}, 32'h1);
    apb_read(12'hF04, rd);
    check("R7 masked value", rd, 32'h0800_0000);

    // R8 clear with ones and zeros
    apb_write(12'hF0C, 32'h0000_0008, 32'h0);
    apb_read(12'hF08, rd);
    check("R8 partial clear", rd, 32'h0800_0000);
    check("R10 irq held", {31'h0, irq_o}, 32'h1);
    apb_write(12'hF0C, 32'h0800_0000, 32'h0);
    check("R10 irq drop lag", {31'h0, irq_o}, 32'h1);
    @(negedge pclk);
    check("R10 irq dropped", {31'h0, irq_o}, 32'h0);
    apb_read(12'hF08, rd);
    check("R8 full clear", rd, 32'h0);

    // R9 set beats clear in the same cycle (pin0 rising edge, bit 16)
    pulse(32'h0001_0000);
    apb_write(12'hF0C, 32'h0001_0000, 32'h0001_0000);
    apb_read(12'hF08, rd);
    check("R9 set wins", rd, 32'h0001_0000);
    apb_write(12'hF0C, 32'h0001_0000, 32'h0000_0100);
    apb_read(12'hF08, rd);
    check("R9 other bit set while clearing", rd, 32'h0000_0100);
    check("R5 bus flags", {30'h0, pready, pslverr}, 32'h2);
  endtask

  initial begin
    checks = 0; fails = 0;
    psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    pin_sync_i = '0; cond_i = '0;
    presetn = 1'b0;
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    fork
      run_tests();
      begin
        repeat (20000) @(posedge pclk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule